// File: doc/BRIEF.md
# Programmed-I/O Byte FIFO with Command Collection Buffer

This block holds the bytes that the host moves one at a time through a single data register while a SCSI-style bus controller runs without DMA. It owns two byte stores of equal depth. The transfer store has a write pointer, a read pointer and a signed occupancy count. The command store gathers command bytes while a selection is paused. Each host write goes to one of three places, chosen by the collect-mode flag and the current bus phase. It can be appended to the command store. It can be thrown away during a data phase, which still lowers the count. Otherwise it is queued in the transfer store.

Host reads drain the transfer store in order and ask for an interrupt. When the count falls back to zero, both pointers return to entry 0. On request the block preloads a two-byte status response: the sense byte followed by zero. It then reports a flags value of 2 and asks for an interrupt. Starting a new selection empties both stores. The signed count is always visible to the register block.

Top module: `pfx_pio_fifo`

## Requirements
- R1: After reset, count_o, rd_data_o, irq_o, flags_wr_o, flags_val_o and cmd_len_o are all 0.
- R2: A write with cmd_mode_i=1 stores wr_data_i at command entry cmd_len_o and raises cmd_len_o by one. Once cmd_len_o equals DEPTH (32), further such writes are dropped. Transfer state is left unchanged. cmd_rdata_o shows the entry selected by cmd_raddr_i.
- R3: A write with cmd_mode_i=0 and phase_i[2:1]!=0 stores the byte at the write pointer and raises count_o by one. Once DEPTH bytes have been stored since the pointers last returned to 0, such writes are dropped and count_o holds.
- R4: A write with cmd_mode_i=0 and phase_i[2:1]==0 (a data phase) is discarded and lowers count_o by one. count_o never goes below -DEPTH, and a discard at that floor is dropped.
- R5: A read when count_o>0 lowers count_o by one, and irq_o is high for the following cycle. In a non-data phase, rd_data_o takes the byte at the read pointer and the pointer advances, so bytes come back in write order. In a data phase, rd_data_o becomes 0 and the pointer holds.
- R6: A read when count_o<=0 has no effect: rd_data_o and count_o hold and irq_o stays low.
- R7: When a read brings count_o to zero, both pointers return to entry 0.
- R8: resp_load_i loads entry 0 with sense_i and entry 1 with 0, sets count_o to 2 and returns both pointers to 0. In the next cycle it pulses flags_wr_o with flags_val_o=2 and pulses irq_o.
- R9: sel_start_i clears count_o, both pointers and cmd_len_o. When several requests arrive in one cycle, the order of precedence is sel_start_i, then resp_load_i, then a write, then a read. Only the winning request takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| sel_start_i | input | 1 | New selection begins: empty both stores |
| resp_load_i | input | 1 | Preload the two-byte status response |
| sense_i | input | 8 | Sense status byte for the response |
| cmd_mode_i | input | 1 | Command-collect mode |
| phase_i | input | 3 | Current bus phase; bits [2:1]==0 mean a data phase |
| wr_en_i | input | 1 | Host write to the data register |
| wr_data_i | input | 8 | Host write byte |
| rd_en_i | input | 1 | Host read from the data register |
| rd_data_o | output | 8 | Data register value returned to the host |
| irq_o | output | 1 | One-cycle interrupt raise request |
| count_o | output | CW (7) | Signed transfer occupancy |
| flags_wr_o | output | 1 | One-cycle strobe that writes the FIFO flags value |
| flags_val_o | output | PW (6) | FIFO flags value |
| cmd_len_o | output | PW (6) | Number of collected command bytes |
| cmd_raddr_i | input | AW (5) | Command store read index |
| cmd_rdata_o | output | 8 | Command store byte at cmd_raddr_i |

## Verification
The random traffic mixes every phase code with and without collect mode, and interleaves reads, response loads and selection starts. This separates the three write routes and the data-phase zero read from a normal pop. Directed runs push 34 writes into each store and 40 discards to tell a drop at the bound from a wrap or an overrun. One sequence leaves the pointers apart when the count reaches zero, so the next read shows whether they really returned to entry 0. Reads of an empty or negative count show whether those reads have any side effect.

// File: rtl/pfx_pkg.sv
package pfx_pkg;
  typedef enum logic [2:0] {
    ACC_IDLE,
    ACC_SEL,
    ACC_RESP,
    ACC_CMD,
    ACC_STORE,
    ACC_DISCARD,
    ACC_POP
  } acc_e;
endpackage

// File: rtl/pfx_access_decode.sv
module pfx_access_decode
  import pfx_pkg::*;
(
  input  logic sel_start,
  input  logic resp_load,
  input  logic wr_en,
  input  logic rd_en,
  input  logic cmd_mode,
  input  logic data_phase,
  input  logic cnt_pos,
  input  logic xfer_full,
  input  logic cmd_full,
  input  logic cnt_floor,
  output acc_e kind
);
  always_comb begin
    kind = ACC_IDLE;
    if (sel_start) begin
      kind = ACC_SEL;
    end else if (resp_load) begin
      kind = ACC_RESP;
    end else if (wr_en) begin
      if (cmd_mode) begin
        if (!cmd_full) kind = ACC_CMD;
      end else if (data_phase) begin
        if (!cnt_floor) kind = ACC_DISCARD;
      end else begin
        if (!xfer_full) kind = ACC_STORE;
      end
    end else if (rd_en && cnt_pos) begin
      kind = ACC_POP;
    end
  end
endmodule

// File: rtl/pfx_byte_bank.sv
module pfx_byte_bank #(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [7:0]    wdata,
  input  logic          pre_en,
  input  logic [7:0]    pre_byte,
  input  logic [AW-1:0] raddr,
  output logic [7:0]    rdata
);
  logic [7:0] mem [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_entry
    logic       ent_en;
    logic [7:0] ent_d;
    always_comb begin
      ent_en = (we && (waddr == AW'(i))) || (pre_en && (i < 2));
      if (pre_en) ent_d = (i == 0) ? pre_byte : 8'h00;
      else        ent_d = wdata;
    end
    always_ff @(posedge clk) begin
      if (ent_en) mem[i] <= ent_d;
    end
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/pfx_xfer_ctrl.sv
module pfx_xfer_ctrl
  import pfx_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(DEPTH) + 2
) (
  input  logic                 clk,
  input  logic                 rst_q,
  input  acc_e                 kind,
  input  logic                 data_phase,
  input  logic [7:0]           wr_data,
  input  logic [7:0]           xfer_rdata,
  output logic                 cnt_pos,
  output logic                 xfer_full,
  output logic                 cmd_full,
  output logic                 cnt_floor,
  output logic                 xfer_we,
  output logic [AW-1:0]        xfer_waddr,
  output logic [AW-1:0]        xfer_raddr,
  output logic                 cmd_we,
  output logic [AW-1:0]        cmd_waddr,
  output logic                 pre_en,
  output logic [7:0]           rd_q,
  output logic                 irq_q,
  output logic                 flw_q,
  output logic [PW-1:0]        flv_q,
  output logic signed [CW-1:0] cnt_q,
  output logic [PW-1:0]        clen_q
);
  localparam logic [PW-1:0]        FULL  = PW'(DEPTH);
  localparam logic [PW-1:0]        P_ONE = PW'(1);
  localparam logic [PW-1:0]        P_TWO = PW'(2);
  localparam logic signed [CW-1:0] C_ONE = CW'(1);
  localparam logic signed [CW-1:0] C_TWO = CW'(2);
  localparam logic signed [CW-1:0] FLOOR = -CW'(DEPTH);

  logic [PW-1:0]        wp_q, rp_q, wp_d, rp_d, clen_d, flv_d;
  logic signed [CW-1:0] cnt_d;
  logic [7:0]           rd_d;
  logic                 irq_d, flw_d;
  logic                 ptr_en, cnt_en, clen_en, rd_en_q, flv_en;

  assign cnt_pos    = cnt_q > 0;
  assign xfer_full  = wp_q == FULL;
  assign cmd_full   = clen_q == FULL;
  assign cnt_floor  = cnt_q == FLOOR;
  assign xfer_we    = kind == ACC_STORE;
  assign xfer_waddr = wp_q[AW-1:0];
  assign xfer_raddr = rp_q[AW-1:0];
  assign cmd_we     = kind == ACC_CMD;
  assign cmd_waddr  = clen_q[AW-1:0];
  assign pre_en     = kind == ACC_RESP;

  always_comb begin
    wp_d = wp_q;   rp_d = rp_q;   cnt_d = cnt_q;  clen_d = clen_q;
    rd_d = rd_q;   flv_d = flv_q; irq_d = 1'b0;   flw_d = 1'b0;
    ptr_en = 1'b0; cnt_en = 1'b0; clen_en = 1'b0; rd_en_q = 1'b0; flv_en = 1'b0;
    unique case (kind)
      ACC_SEL: begin
        wp_d = '0; rp_d = '0; cnt_d = '0; clen_d = '0;
        ptr_en = 1'b1; cnt_en = 1'b1; clen_en = 1'b1;
      end
      ACC_RESP: begin
        wp_d = '0; rp_d = '0; cnt_d = C_TWO; flv_d = P_TWO;
        ptr_en = 1'b1; cnt_en = 1'b1; flv_en = 1'b1;
        irq_d = 1'b1; flw_d = 1'b1;
      end
      ACC_CMD: begin
        clen_d = clen_q + P_ONE; clen_en = 1'b1;
      end
      ACC_STORE: begin
        wp_d = wp_q + P_ONE; cnt_d = cnt_q + C_ONE;
        ptr_en = 1'b1; cnt_en = 1'b1;
      end
      ACC_DISCARD: begin
        cnt_d = cnt_q - C_ONE; cnt_en = 1'b1;
      end
      ACC_POP: begin
        cnt_d = cnt_q - C_ONE; cnt_en = 1'b1; rd_en_q = 1'b1; irq_d = 1'b1;
        if (data_phase) begin
          rd_d = 8'h00;
        end else begin
          rd_d = xfer_rdata; rp_d = rp_q + P_ONE; ptr_en = 1'b1;
        end
        if (cnt_q == C_ONE) begin
          wp_d = '0; rp_d = '0; ptr_en = 1'b1;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk or negedge rst_q) begin
    if (!rst_q) begin
      wp_q <= '0; rp_q <= '0; cnt_q <= '0; clen_q <= '0;
      rd_q <= '0; irq_q <= 1'b0; flw_q <= 1'b0; flv_q <= '0;
    end else begin
      irq_q <= irq_d;
      flw_q <= flw_d;
      if (ptr_en)  begin wp_q <= wp_d; rp_q <= rp_d; end
      if (cnt_en)  cnt_q  <= cnt_d;
      if (clen_en) clen_q <= clen_d;
      if (rd_en_q) rd_q   <= rd_d;
      if (flv_en)  flv_q  <= flv_d;
    end
  end

  // R3: write pointer never passes the store depth
  a_r3_wptr_bound: assert property (@(posedge clk) disable iff (!rst_q)
    wp_q <= FULL && rp_q <= FULL);
  // R4: count never drops under the floor
  a_r4_count_floor: assert property (@(posedge clk) disable iff (!rst_q)
    cnt_q >= FLOOR);
  // R7: a pop that empties the store returns both pointers to 0
  a_r7_ptr_home: assert property (@(posedge clk) disable iff (!rst_q)
    (kind == ACC_POP && cnt_q == C_ONE) |=> (wp_q == '0 && rp_q == '0));
  // R8: flags strobe comes with a fresh two-byte response
  a_r8_flags_resp: assert property (@(posedge clk) disable iff (!rst_q)
    flw_q |-> (cnt_q == C_TWO && wp_q == '0 && rp_q == '0 && irq_q));
endmodule

// File: rtl/pfx_pio_fifo.sv
module pfx_pio_fifo
  import pfx_pkg::*;
#(
  parameter int DEPTH = 32,
  localparam int AW = $clog2(DEPTH),
  localparam int PW = $clog2(DEPTH + 1),
  localparam int CW = $clog2(DEPTH) + 2
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sel_start_i,
  input  logic                 resp_load_i,
  input  logic [7:0]           sense_i,
  input  logic                 cmd_mode_i,
  input  logic [2:0]           phase_i,
  input  logic                 wr_en_i,
  input  logic [7:0]           wr_data_i,
  input  logic                 rd_en_i,
  output logic [7:0]           rd_data_o,
  output logic                 irq_o,
  output logic signed [CW-1:0] count_o,
  output logic                 flags_wr_o,
  output logic [PW-1:0]        flags_val_o,
  output logic [PW-1:0]        cmd_len_o,
  input  logic [AW-1:0]        cmd_raddr_i,
  output logic [7:0]           cmd_rdata_o
);
  logic rst_meta, rst_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_q    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_q    <= rst_meta;
    end
  end

  acc_e          kind;
  logic          data_phase, cnt_pos, xfer_full, cmd_full, cnt_floor;
  logic          xfer_we, cmd_we, pre_en;
  logic [AW-1:0] xfer_waddr, xfer_raddr, cmd_waddr;
  logic [7:0]    xfer_rdata;

  assign data_phase = phase_i[2:1] == 2'b00;

  pfx_access_decode u_dec (
    .sel_start (sel_start_i), .resp_load (resp_load_i),
    .wr_en     (wr_en_i),     .rd_en     (rd_en_i),
    .cmd_mode  (cmd_mode_i),  .data_phase(data_phase),
    .cnt_pos   (cnt_pos),     .xfer_full (xfer_full),
    .cmd_full  (cmd_full),    .cnt_floor (cnt_floor),
    .kind      (kind)
  );

  pfx_xfer_ctrl #(.DEPTH(DEPTH)) u_ctl (
    .clk       (clk),        .rst_q     (rst_q),
    .kind      (kind),       .data_phase(data_phase),
    .wr_data   (wr_data_i),  .xfer_rdata(xfer_rdata),
    .cnt_pos   (cnt_pos),    .xfer_full (xfer_full),
    .cmd_full  (cmd_full),   .cnt_floor (cnt_floor),
    .xfer_we   (xfer_we),    .xfer_waddr(xfer_waddr),
    .xfer_raddr(xfer_raddr), .cmd_we    (cmd_we),
    .cmd_waddr (cmd_waddr),  .pre_en    (pre_en),
    .rd_q      (rd_data_o),  .irq_q     (irq_o),
    .flw_q     (flags_wr_o), .flv_q     (flags_val_o),
    .cnt_q     (count_o),    .clen_q    (cmd_len_o)
  );

  pfx_byte_bank #(.DEPTH(DEPTH)) u_xfer (
    .clk(clk), .we(xfer_we), .waddr(xfer_waddr), .wdata(wr_data_i),
    .pre_en(pre_en), .pre_byte(sense_i), .raddr(xfer_raddr), .rdata(xfer_rdata)
  );

  pfx_byte_bank #(.DEPTH(DEPTH)) u_cmd (
    .clk(clk), .we(cmd_we), .waddr(cmd_waddr), .wdata(wr_data_i),
    .pre_en(1'b0), .pre_byte(8'h00), .raddr(cmd_raddr_i), .rdata(cmd_rdata_o)
  );

  logic lone_rd;
  assign lone_rd = rd_en_i && !wr_en_i && !sel_start_i && !resp_load_i;

  // R5: a read with data pending asks for an interrupt one cycle later
  a_r5_pop_irq: assert property (@(posedge clk) disable iff (!rst_q)
    (lone_rd && count_o > 0) |=> (irq_o && count_o == $past(count_o) - 1));
  // R6: a read with nothing pending leaves the outputs alone
  a_r6_empty_hold: assert property (@(posedge clk) disable iff (!rst_q)
    (lone_rd && count_o <= 0) |=> ($stable(rd_data_o) && $stable(count_o) && !irq_o));
  // R9: a selection start empties both stores
  a_r9_sel_clear: assert property (@(posedge clk) disable iff (!rst_q)
    sel_start_i |=> (count_o == 0 && cmd_len_o == 0 && !irq_o));
endmodule

// File: tb/sim_pfx_pio_fifo.sv
module sim_pfx_pio_fifo;
  localparam int DEPTH = 32;
  localparam int AW = $clog2(DEPTH);
  localparam int PW = $clog2(DEPTH + 1);
  localparam int CW = $clog2(DEPTH) + 2;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, sel, resp, cm, wr, rd;
  logic [7:0] sense, wd, rdd, crd;
  logic [2:0] ph;
  logic irq, flw;
  logic signed [CW-1:0] cnt;
  logic [PW-1:0] flv, clen;
  logic [AW-1:0] craddr;

  pfx_pio_fifo #(.DEPTH(DEPTH)) u0 (
    .clk(clk), .rst_n(rst_n), .sel_start_i(sel), .resp_load_i(resp),
    .sense_i(sense), .cmd_mode_i(cm), .phase_i(ph), .wr_en_i(wr),
    .wr_data_i(wd), .rd_en_i(rd), .rd_data_o(rdd), .irq_o(irq),
    .count_o(cnt), .flags_wr_o(flw), .flags_val_o(flv), .cmd_len_o(clen),
    .cmd_raddr_i(craddr), .cmd_rdata_o(crd)
  );

  int checks = 0, errors = 0;
  bit done = 0;

  // reference state
  logic [7:0] m_buf [DEPTH];
  logic [7:0] m_cmd [DEPTH];
  int m_wp, m_rp, m_cnt, m_clen, m_flv;
  logic [7:0] m_rd;
  bit m_irq, m_flw;

  task automatic chk(string tag, int act, int exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic bit is_data(logic [2:0] p);
    return p[2:1] == 2'b00;
  endfunction

  task automatic model(bit s, bit rl, bit w, bit r, bit c, logic [2:0] p,
                       logic [7:0] d, logic [7:0] sn, output string tag);
    m_irq = 0; m_flw = 0; tag = "R6";
    if (s) begin
      tag = "R9"; m_cnt = 0; m_wp = 0; m_rp = 0; m_clen = 0;
    end else if (rl) begin
      tag = "R8"; m_buf[0] = sn; m_buf[1] = 8'h00; m_cnt = 2; m_wp = 0; m_rp = 0;
      m_flv = 2; m_flw = 1; m_irq = 1;
    end else if (w) begin
      if (c) begin
        tag = "R2";
        if (m_clen < DEPTH) begin m_cmd[m_clen] = d; m_clen++; end
      end else if (is_data(p)) begin
        tag = "R4";
        if (m_cnt > -DEPTH) m_cnt--;
      end else begin
        tag = "R3";
        if (m_wp < DEPTH) begin m_buf[m_wp] = d; m_wp++; m_cnt++; end
      end
    end else if (r && m_cnt > 0) begin
      tag = "R5"; m_cnt--; m_irq = 1;
      if (is_data(p)) m_rd = 8'h00;
      else begin m_rd = m_buf[m_rp]; m_rp++; end
      if (m_cnt == 0) begin m_wp = 0; m_rp = 0; tag = "R7"; end
    end
  endtask

  task automatic op(bit s, bit rl, bit w, bit r, bit c, logic [2:0] p,
                    logic [7:0] d, logic [7:0] sn);
    string tag;
    @(negedge clk);
    sel = s; resp = rl; wr = w; rd = r; cm = c; ph = p; wd = d; sense = sn;
    @(posedge clk);
    #1;
    sel = 0; resp = 0; wr = 0; rd = 0;
    model(s, rl, w, r, c, p, d, sn, tag);
    chk({tag, " count"}, int'(cnt), m_cnt);
    chk({tag, " rd_data"}, int'(rdd), int'(m_rd));
    chk({tag, " irq"}, int'(irq), int'(m_irq));
    chk({tag, " flags_wr"}, int'(flw), int'(m_flw));
    chk({tag, " flags_val"}, int'(flv), m_flv);
    chk({tag, " cmd_len"}, int'(clen), m_clen);
  endtask

  task automatic check_cmd_store(string tag);
    for (int i = 0; i < m_clen; i++) begin
      craddr = AW'(i);
      #1;
      chk(tag, int'(crd), int'(m_cmd[i]));
    end
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed_0042));
    rst_n = 0; sel = 0; resp = 0; cm = 0; wr = 0; rd = 0;
    ph = 3'd3; wd = 0; sense = 0; craddr = 0;
    m_wp = 0; m_rp = 0; m_cnt = 0; m_clen = 0; m_flv = 0;
    m_rd = 0; m_irq = 0; m_flw = 0;
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    repeat (4) @(posedge clk);
    #1;
    // R1 reset state
    chk("R1 count", int'(cnt), 0);
    chk("R1 rd_data", int'(rdd), 0);
    chk("R1 irq", int'(irq), 0);
    chk("R1 flags_wr", int'(flw), 0);
    chk("R1 flags_val", int'(flv), 0);
    chk("R1 cmd_len", int'(clen), 0);

    // R6 read on empty store
    op(0, 0, 0, 1, 0, 3'd3, 8'h00, 8'h00);

    // R3 fill past depth, then R5 drain in order
    for (int i = 0; i < DEPTH + 2; i++) op(0, 0, 1, 0, 0, 3'd3, 8'(8'hA0 + i), 8'h00);
    chk("R3 full count", int'(cnt), DEPTH);
    for (int i = 0; i < DEPTH; i++) op(0, 0, 0, 1, 0, 3'd3, 8'h00, 8'h00);
    chk("R7 drained count", int'(cnt), 0);

    // R7 pointers home while apart
    op(0, 0, 1, 0, 0, 3'd2, 8'h11, 8'h00);
    op(0, 0, 1, 0, 0, 3'd2, 8'h22, 8'h00);
    op(0, 0, 1, 0, 0, 3'd0, 8'h33, 8'h00);
    op(0, 0, 0, 1, 0, 3'd2, 8'h00, 8'h00);
    op(0, 0, 1, 0, 0, 3'd2, 8'h5C, 8'h00);
    op(0, 0, 0, 1, 0, 3'd2, 8'h00, 8'h00);
    chk("R7 entry0 reread", int'(rdd), 8'h5C);

    // R4 discard down to the floor, R6 read while negative
    for (int i = 0; i < DEPTH + 8; i++) op(0, 0, 1, 0, 0, 3'd1, 8'hEE, 8'h00);
    chk("R4 floor", int'(cnt), -DEPTH);
    op(0, 0, 0, 1, 0, 3'd3, 8'h00, 8'h00);

    // R9 selection start, R2 command collection past depth
    op(1, 0, 0, 0, 0, 3'd3, 8'h00, 8'h00);
    for (int i = 0; i < DEPTH + 2; i++) op(0, 0, 1, 0, 1, 3'd0, 8'(8'h40 + 3 * i), 8'h00);
    chk("R2 cmd full", int'(clen), DEPTH);
    check_cmd_store("R2 cmd byte");

    // R8 response, then R5 data-phase pop returns 0 and keeps pointer
    op(0, 1, 0, 0, 0, 3'd3, 8'h00, 8'h8B);
    op(0, 0, 0, 1, 0, 3'd0, 8'h00, 8'h00);
    chk("R5 data phase zero", int'(rdd), 0);
    op(0, 0, 0, 1, 0, 3'd3, 8'h00, 8'h00);
    chk("R8 sense byte", int'(rdd), 8'h8B);

    // R9 precedence: everything at once
    op(1, 1, 1, 1, 0, 3'd3, 8'h77, 8'h99);
    op(0, 1, 1, 1, 0, 3'd3, 8'h77, 8'h99);

    // random mix
    for (int n = 0; n < 3000; n++) begin
      int k;
      bit s, rl, w, r, c;
      k = int'($urandom_range(0, 99));
      s  = (k < 2);
      rl = (k >= 2 && k < 5);
      w  = (k >= 5 && k < 55);
      r  = (k >= 50);
      c  = ($urandom_range(0, 9) == 0);
      op(s, rl, w, r, c, 3'($urandom_range(0, 7)), 8'($urandom), 8'($urandom));
    end
    check_cmd_store("R2 random cmd byte");

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule